// File: doc/BRIEF.md
# Two-Wire Digital Potentiometer Command Slave

This block is the serial front end of a single-wiper digital potentiometer. It watches a two-wire bus (clock and data), synchronises both lines into the system clock domain, and finds start and stop conditions. It checks the address byte against a fixed device identifier and two strap pins, then decodes an instruction byte. The data line is driven only as an open-drain pull-down, through an output enable, and the resolved line value is read back.

Writes carry a 10-bit value split across two bytes. Reads shift a 10-bit value out in the same two-byte form. Transfers between the wiper register and one of four data registers carry no payload. The block does not hold the wiper or the data registers. It presents a combinational read selection to the register bank, and it raises a one-cycle request when a write or transfer frame is closed by a stop. While the bank reports that a nonvolatile write is still in progress, the block refuses its own address. A bus master can therefore poll for completion by sending the address repeatedly.

Top module: `pot_cmd_slave`

## Requirements
- R1: During and after reset the data output enable is low and no request is raised.
- R2: An address byte is accepted only when bits 7:4 are 0101, bit 3 is 0, bits 2:1 equal `dev_addr_i`, and bit 0 is the direction (1 = read). An accepted address is acknowledged by pulling the line low for the ninth clock.
- R3: After an address byte that is not accepted, the block leaves the line released for every following bit until the next start.
- R4: The instruction byte holds the opcode in bits 7:5 and the register select in bits 3:2. Bits 4, 1 and 0 must be zero. With the direction bit, it decodes as follows: read=1/100 reads the wiper; write=0/101 writes the wiper; read=1/101 reads a data register; write=0/110 writes a data register; read=1/111 loads the wiper from a data register; write=0/111 saves the wiper into a data register. Any other byte is not acknowledged and the frame is ignored until the next start.
- R5: A write command is followed by two data bytes, each acknowledged. The first byte's bits 1:0 are value bits 9:8 and its upper six bits are ignored. The second byte is value bits 7:0. At the stop the block issues a request with kind 0 (write wiper) or 1 (write data register), the select from bits 3:2, and the value.
- R6: A read command returns first the byte {000000, value[9:8]} and then value[7:0], MSB first. The value is taken from `rd_data_i` with `rd_wiper_o` high for a wiper read, or low with `rd_sel_o` naming the data register.
- R7: A transfer command ends after its acknowledged instruction byte. The stop then issues kind 2 (load wiper from data register) or kind 3 (save wiper into data register) with the select.
- R8: While `bank_busy_i` is high at the end of the address byte, the address is not acknowledged. Once the flag is low, the address is acknowledged again.
- R9: A frame that ends with a stop before its last byte (a write with fewer than two data bytes) issues no request and changes nothing in the bank.
- R10: A request is a single-cycle pulse, raised only in the cycle after a stop is detected.
- R11: On a read, the line is released after the second data byte whether or not the master acknowledges, and it stays released until the stop.
- R12: A start seen in any state, including a repeated start in the middle of a frame, restarts address reception and discards the unfinished frame.
- R13: The block changes the line only while the clock is low, and it samples incoming bits on the clock's rising edge. An output bit is stable for the whole high phase of the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Resolved value of the bus data line |
| dev_addr_i | input | 2 | Strap pins compared with address bits 2:1 |
| bank_busy_i | input | 1 | Bank is busy with a nonvolatile write |
| rd_data_i | input | VAL_W | Value of the register named by the read selection |
| sda_oe_o | output | 1 | Pull the data line low when high |
| rd_wiper_o | output | 1 | Read selection: wiper register (high) or data register |
| rd_sel_o | output | 2 | Data register index for reads and requests |
| req_valid_o | output | 1 | One-cycle request strobe |
| req_kind_o | output | 2 | Request kind: 0 write wiper, 1 write data, 2 load wiper, 3 save wiper |
| req_sel_o | output | 2 | Data register index of the request |
| req_val_o | output | VAL_W | Value written by a write request |

## Verification
The hardest case to reach is the refused address while the bank is busy. The busy window has to cover the exact cycle in which the eighth address bit ends. The bench's bank model starts a long busy window on every nonvolatile request, and the bench polls at once after the stop, so the first poll falls inside the window. Later polls then walk past its end until one is acknowledged. A repeated start issued after a partial write shows that an unfinished frame leaves no trace, because the frame that follows reads back the unchanged wiper.

// File: rtl/pot_slave_pkg.sv
package pot_slave_pkg;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_RD_WIPER,
        CMD_WR_WIPER,
        CMD_RD_DATA,
        CMD_WR_DATA,
        CMD_LD_WIPER,
        CMD_SV_WIPER
    } cmd_e;

    typedef enum logic [1:0] {
        REQ_WR_WIPER = 2'd0,
        REQ_WR_DATA  = 2'd1,
        REQ_LD_WIPER = 2'd2,
        REQ_SV_WIPER = 2'd3
    } req_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_HOLD
    } state_e;

    typedef enum logic [2:0] {
        PH_ADDR,
        PH_INSTR,
        PH_DHI,
        PH_DLO,
        PH_END
    } phase_e;

endpackage

// File: rtl/twowire_line_sync.sv
module twowire_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES-1:0] scl_pipe_q;
    logic [STAGES-1:0] sda_pipe_q;
    logic              scl_prev_q;
    logic              sda_prev_q;

    generate
        if (STAGES > 1) begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe_q <= '1;
                    sda_pipe_q <= '1;
                end else begin
                    scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
                    sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe_q <= '1;
                    sda_pipe_q <= '1;
                end else begin
                    scl_pipe_q <= scl_i;
                    sda_pipe_q <= sda_i;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_pipe_q[STAGES-1];
            sda_prev_q <= sda_pipe_q[STAGES-1];
        end
    end

    assign scl_o   = scl_pipe_q[STAGES-1];
    assign sda_o   = sda_pipe_q[STAGES-1];
    assign start_o = scl_o & scl_prev_q & sda_prev_q & ~sda_o;
    assign stop_o  = scl_o & scl_prev_q & ~sda_prev_q & sda_o;
    assign rise_o  = scl_o & ~scl_prev_q;
    assign fall_o  = ~scl_o & scl_prev_q;

endmodule

// File: rtl/pot_instr_decode.sv
module pot_instr_decode
    import pot_slave_pkg::*;
(
    input  logic       rw_i,
    input  logic [7:0] instr_i,
    output cmd_e       cmd_o,
    output logic [1:0] sel_o
);

    logic reserved_clear;

    always_comb begin
        reserved_clear = ~instr_i[4] & ~instr_i[1] & ~instr_i[0];
        sel_o          = instr_i[3:2];
        cmd_o          = CMD_NONE;
        if (reserved_clear) begin
            case ({rw_i, instr_i[7:5]})
                4'b1_100: cmd_o = CMD_RD_WIPER;
                4'b0_101: cmd_o = CMD_WR_WIPER;
                4'b1_101: cmd_o = CMD_RD_DATA;
                4'b0_110: cmd_o = CMD_WR_DATA;
                4'b1_111: cmd_o = CMD_LD_WIPER;
                4'b0_111: cmd_o = CMD_SV_WIPER;
                default:  cmd_o = CMD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/pot_cmd_slave.sv
module pot_cmd_slave
    import pot_slave_pkg::*;
#(
    parameter int         VAL_W       = 10,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_ID      = 4'b0101
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [1:0]       dev_addr_i,
    input  logic             bank_busy_i,
    input  logic [VAL_W-1:0] rd_data_i,
    output logic             sda_oe_o,
    output logic             rd_wiper_o,
    output logic [1:0]       rd_sel_o,
    output logic             req_valid_o,
    output logic [1:0]       req_kind_o,
    output logic [1:0]       req_sel_o,
    output logic [VAL_W-1:0] req_val_o
);

    localparam int HI_W = VAL_W - 8;

    typedef struct packed {
        state_e           state;
        phase_e           phase;
        logic [3:0]       cnt;
        logic [7:0]       shreg;
        logic             oe;
        logic             rw;
        cmd_e             cmd;
        logic [1:0]       sel;
        logic [VAL_W-1:0] val;
        logic             pending;
        logic             req_valid;
        req_e             req_kind;
        logic [1:0]       req_sel;
        logic [VAL_W-1:0] req_val;
    } regs_t;

    regs_t r_d, r_q;

    logic       scl_s, sda_s, start_det, stop_det, scl_rise, scl_fall;
    cmd_e       dec_cmd;
    logic [1:0] dec_sel;
    logic       addr_ok;
    logic [7:0] hi_byte;

    twowire_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_o   (scl_s),
        .sda_o   (sda_s),
        .start_o (start_det),
        .stop_o  (stop_det),
        .rise_o  (scl_rise),
        .fall_o  (scl_fall)
    );

    pot_instr_decode u_dec (
        .rw_i    (r_q.rw),
        .instr_i (r_q.shreg),
        .cmd_o   (dec_cmd),
        .sel_o   (dec_sel)
    );

    function automatic req_e kind_of(input cmd_e c);
        case (c)
            CMD_WR_DATA:  return REQ_WR_DATA;
            CMD_LD_WIPER: return REQ_LD_WIPER;
            CMD_SV_WIPER: return REQ_SV_WIPER;
            default:      return REQ_WR_WIPER;
        endcase
    endfunction

    always_comb begin
        r_d       = r_q;
        r_d.req_valid = 1'b0;
        addr_ok   = (r_q.shreg[7:4] == DEV_ID) && !r_q.shreg[3]
                    && (r_q.shreg[2:1] == dev_addr_i);
        hi_byte   = '0;
        hi_byte[HI_W-1:0] = rd_data_i[VAL_W-1:8];

        if (start_det) begin
            r_d.state   = ST_RX;
            r_d.phase   = PH_ADDR;
            r_d.cnt     = '0;
            r_d.oe      = 1'b0;
            r_d.pending = 1'b0;
        end else if (stop_det) begin
            if (r_q.state == ST_HOLD && r_q.pending) begin
                r_d.req_valid = 1'b1;
                r_d.req_kind  = kind_of(r_q.cmd);
                r_d.req_sel   = r_q.sel;
                r_d.req_val   = r_q.val;
            end
            r_d.state   = ST_IDLE;
            r_d.oe      = 1'b0;
            r_d.pending = 1'b0;
        end else begin
            case (r_q.state)
                ST_RX: begin
                    if (scl_rise) begin
                        r_d.shreg = {r_q.shreg[6:0], sda_s};
                        r_d.cnt   = r_q.cnt + 4'd1;
                    end else if (scl_fall && r_q.cnt == 4'd8) begin
                        r_d.cnt   = '0;
                        r_d.state = ST_ACK;
                        r_d.oe    = 1'b1;
                        case (r_q.phase)
                            PH_ADDR: begin
                                if (addr_ok && !bank_busy_i) begin
                                    r_d.rw    = r_q.shreg[0];
                                    r_d.phase = PH_INSTR;
                                end else begin
                                    r_d.state = ST_IDLE;
                                    r_d.oe    = 1'b0;
                                end
                            end
                            PH_INSTR: begin
                                if (dec_cmd != CMD_NONE) begin
                                    r_d.cmd   = dec_cmd;
                                    r_d.sel   = dec_sel;
                                    r_d.phase = PH_DHI;
                                end else begin
                                    r_d.state = ST_IDLE;
                                    r_d.oe    = 1'b0;
                                end
                            end
                            PH_DHI: begin
                                r_d.val[VAL_W-1:8] = r_q.shreg[HI_W-1:0];
                                r_d.phase          = PH_DLO;
                            end
                            PH_DLO: begin
                                r_d.val[7:0] = r_q.shreg;
                                r_d.phase    = PH_END;
                            end
                            default: begin
                                r_d.state = ST_IDLE;
                                r_d.oe    = 1'b0;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        r_d.oe = 1'b0;
                        case (r_q.phase)
                            PH_INSTR, PH_DLO: r_d.state = ST_RX;
                            PH_DHI: begin
                                if (r_q.cmd == CMD_RD_WIPER || r_q.cmd == CMD_RD_DATA) begin
                                    r_d.val   = rd_data_i;
                                    r_d.shreg = hi_byte;
                                    r_d.oe    = ~hi_byte[7];
                                    r_d.state = ST_TX;
                                end else if (r_q.cmd == CMD_WR_WIPER || r_q.cmd == CMD_WR_DATA) begin
                                    r_d.state = ST_RX;
                                end else begin
                                    r_d.state   = ST_HOLD;
                                    r_d.pending = 1'b1;
                                end
                            end
                            default: begin
                                r_d.state   = ST_HOLD;
                                r_d.pending = 1'b1;
                            end
                        endcase
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (r_q.cnt == 4'd7) begin
                            r_d.oe    = 1'b0;
                            r_d.cnt   = '0;
                            r_d.state = ST_MACK;
                        end else begin
                            r_d.shreg = {r_q.shreg[6:0], 1'b0};
                            r_d.oe    = ~r_q.shreg[6];
                            r_d.cnt   = r_q.cnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_fall) begin
                        if (r_q.phase == PH_DHI) begin
                            r_d.shreg = r_q.val[7:0];
                            r_d.oe    = ~r_q.val[7];
                            r_d.phase = PH_DLO;
                            r_d.state = ST_TX;
                        end else begin
                            r_d.state = ST_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sda_oe_o    = r_q.oe;
    assign rd_wiper_o  = (r_q.cmd == CMD_RD_WIPER);
    assign rd_sel_o    = r_q.sel;
    assign req_valid_o = r_q.req_valid;
    assign req_kind_o  = r_q.req_kind;
    assign req_sel_o   = r_q.req_sel;
    assign req_val_o   = r_q.req_val;

    // R1: an idle slave never pulls the line
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE) |-> !sda_oe_o);

    // R8: an address acknowledge starts only if the bank was idle at the decision
    a_r8_busy_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ACK && r_q.phase == PH_INSTR && $past(r_q.state) == ST_RX)
        |-> !$past(bank_busy_i));

    // R10: requests follow a detected stop and last one cycle
    a_r10_req_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> $past(stop_det));
    a_r10_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |=> !req_valid_o);

    // R11: after the last read byte, or in any finished frame, the line is released
    a_r11_hold_released: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_HOLD) |-> !sda_oe_o);

    // R13: apart from start/stop handling, the enable moves only while SCL is low
    a_r13_change_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe_o) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);

endmodule

// File: tb/tb_pot_cmd_slave.sv
module tb_pot_cmd_slave;
    import pot_slave_pkg::*;

    localparam int Q        = 8;
    localparam int BUSY_CYC = 700;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] pins  = 2'b01;
    logic       sda_oe, sda_line;
    logic       rd_wiper, busy;
    logic [1:0] rd_sel;
    logic [9:0] rd_data;
    logic       req_valid;
    logic [1:0] req_kind, req_sel;
    logic [9:0] req_val;

    assign sda_line = sda_m & ~sda_oe;

    logic [9:0] wiper_m;
    logic [9:0] dreg_m [4];
    int         busy_cnt = 0;
    assign busy    = (busy_cnt != 0);
    assign rd_data = rd_wiper ? wiper_m : dreg_m[rd_sel];

    pot_cmd_slave dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .dev_addr_i  (pins),
        .bank_busy_i (busy),
        .rd_data_i   (rd_data),
        .sda_oe_o    (sda_oe),
        .rd_wiper_o  (rd_wiper),
        .rd_sel_o    (rd_sel),
        .req_valid_o (req_valid),
        .req_kind_o  (req_kind),
        .req_sel_o   (req_sel),
        .req_val_o   (req_val)
    );

    int vectors = 0;
    int miscompares = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct {
        int    kind;
        int    sel;
        int    val;
        bit    chk_val;
        string tag;
    } exp_t;
    exp_t exp_q[$];
    exp_t cur;
    logic prev_req = 1'b0;

    // monitor: pops expected requests as the design raises them
    always @(negedge clk) begin
        if (req_valid) begin
            check(!prev_req, "R10 request pulse width", int'(prev_req), 0);
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected request", int'(req_kind), -1);
            end else begin
                cur = exp_q.pop_front();
                check(int'(req_kind) == cur.kind, {cur.tag, " request kind"}, int'(req_kind), cur.kind);
                check(int'(req_sel) == cur.sel, {cur.tag, " request select"}, int'(req_sel), cur.sel);
                if (cur.chk_val)
                    check(int'(req_val) == cur.val, {cur.tag, " request value"}, int'(req_val), cur.val);
            end
        end
        prev_req = req_valid;
    end

    // bank model
    always @(negedge clk) begin
        if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
        if (req_valid) begin
            case (req_kind)
                2'd0: wiper_m = req_val;
                2'd1: begin dreg_m[req_sel] = req_val; busy_cnt = BUSY_CYC; end
                2'd2: wiper_m = dreg_m[req_sel];
                default: begin dreg_m[req_sel] = wiper_m; busy_cnt = BUSY_CYC; end
            endcase
        end
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
    endtask

    task automatic put_bit(input bit b);
        sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    endtask

    task automatic get_bit(output bit b);
        bit b2;
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        b = sda_line; wq();
        b2 = sda_line;
        check(b == b2, "R13 bit stable during SCL high", int'(b2), int'(b));
        scl_m = 1'b0; wq();
    endtask

    task automatic put_byte(input logic [7:0] d, output bit ack);
        bit nb;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(nb);
        ack = !nb;
    endtask

    task automatic get_byte(output logic [7:0] d, input bit mack);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(!mack);
    endtask

    function automatic logic [7:0] addr_b(input logic [1:0] a, input bit rw);
        return {4'b0101, 1'b0, a, rw};
    endfunction

    function automatic logic [7:0] ins_b(input logic [2:0] op, input logic [1:0] sel);
        return {op, 1'b0, sel, 2'b00};
    endfunction

    task automatic wr_cmd(input logic [2:0] op, input logic [1:0] sel, input logic [9:0] v,
                          input int kind);
        bit a;
        exp_t e;
        bus_start();
        put_byte(addr_b(pins, 1'b0), a); check(a, "R2 address ack", int'(a), 1);
        put_byte(ins_b(op, sel), a);     check(a, "R4 instruction ack", int'(a), 1);
        put_byte({6'b101101, v[9:8]}, a); check(a, "R5 high data ack", int'(a), 1);
        put_byte(v[7:0], a);             check(a, "R5 low data ack", int'(a), 1);
        e.kind = kind; e.sel = int'(sel); e.val = int'(v); e.chk_val = 1'b1; e.tag = "R5";
        exp_q.push_back(e);
        bus_stop();
    endtask

    task automatic xfer_cmd(input bit rw, input logic [1:0] sel, input int kind);
        bit a;
        exp_t e;
        bus_start();
        put_byte(addr_b(pins, rw), a);      check(a, "R2 address ack", int'(a), 1);
        put_byte(ins_b(3'b111, sel), a);    check(a, "R7 transfer ack", int'(a), 1);
        e.kind = kind; e.sel = int'(sel); e.val = 0; e.chk_val = 1'b0; e.tag = "R7";
        exp_q.push_back(e);
        bus_stop();
    endtask

    task automatic rd_cmd(input logic [2:0] op, input logic [1:0] sel, input logic [9:0] v,
                          input bit mack2, input bit extra, output logic [9:0] got);
        bit a;
        logic [7:0] hi, lo, x;
        bus_start();
        put_byte(addr_b(pins, 1'b1), a); check(a, "R2 address ack", int'(a), 1);
        put_byte(ins_b(op, sel), a);     check(a, "R4 instruction ack", int'(a), 1);
        get_byte(hi, 1'b1);
        get_byte(lo, mack2);
        check(hi == {6'b0, v[9:8]}, "R6 read high byte", int'(hi), int'({6'b0, v[9:8]}));
        check(lo == v[7:0], "R6 read low byte", int'(lo), int'(v[7:0]));
        got = {hi[1:0], lo};
        if (extra) begin
            get_byte(x, 1'b0);
            check(x == 8'hFF, "R11 line released after second byte", int'(x), 8'hFF);
        end
        bus_stop();
    endtask

    task automatic poll(output bit a);
        bus_start();
        put_byte(addr_b(pins, 1'b0), a);
        bus_stop();
    endtask

    task automatic wait_ready();
        bit a = 1'b0;
        for (int i = 0; i < 10 && !a; i++) poll(a);
        check(a, "R8 address acknowledged once idle", int'(a), 1);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        miscompares++;
        $display("FAIL R1 watchdog expired actual=%0h expected=%0h", 1, 0);
        summary();
        $finish;
    end

    initial begin
        bit a;
        logic [9:0] got;
        wiper_m = 10'h000;
        dreg_m[0] = 10'h111; dreg_m[1] = 10'h222; dreg_m[2] = 10'h0AB; dreg_m[3] = 10'h3C0;

        repeat (4) @(negedge clk);
        check(sda_oe == 1'b0, "R1 output enable in reset", int'(sda_oe), 0);
        check(req_valid == 1'b0, "R1 request in reset", int'(req_valid), 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check(sda_oe == 1'b0, "R1 output enable after reset", int'(sda_oe), 0);

        // write then read the wiper
        wr_cmd(3'b101, 2'd0, 10'h2A5, 0);
        rd_cmd(3'b100, 2'd0, 10'h2A5, 1'b0, 1'b0, got);
        rd_cmd(3'b101, 2'd2, 10'h0AB, 1'b0, 1'b0, got);

        // nonvolatile write, then busy polling (R8)
        wr_cmd(3'b110, 2'd1, 10'h13C, 1);
        poll(a);
        check(!a, "R8 address refused while busy", int'(a), 0);
        wait_ready();
        rd_cmd(3'b101, 2'd1, 10'h13C, 1'b0, 1'b0, got);

        // transfers (R7)
        xfer_cmd(1'b1, 2'd1, 2);
        rd_cmd(3'b100, 2'd0, 10'h13C, 1'b0, 1'b0, got);
        wr_cmd(3'b101, 2'd0, 10'h3FF, 0);
        xfer_cmd(1'b0, 2'd3, 3);
        wait_ready();
        rd_cmd(3'b101, 2'd3, 10'h3FF, 1'b0, 1'b0, got);

        // R3: foreign strap address, rest of frame ignored
        bus_start();
        put_byte(addr_b(~pins, 1'b0), a); check(!a, "R3 foreign address refused", int'(a), 0);
        put_byte(ins_b(3'b101, 2'd0), a); check(!a, "R3 later byte ignored", int'(a), 0);
        put_byte(8'h00, a);               check(!a, "R3 data byte ignored", int'(a), 0);
        bus_stop();
        rd_cmd(3'b100, 2'd0, 10'h3FF, 1'b0, 1'b0, got);
        check(got == 10'h3FF, "R3 wiper unchanged", int'(got), 10'h3FF);

        // R2: wrong identifier and nonzero bit 3
        bus_start();
        put_byte({4'b0110, 1'b0, pins, 1'b0}, a); check(!a, "R2 wrong identifier", int'(a), 0);
        bus_stop();
        bus_start();
        put_byte({4'b0101, 1'b1, pins, 1'b0}, a); check(!a, "R2 bit 3 set", int'(a), 0);
        bus_stop();

        // R4: illegal instruction bytes
        bus_start();
        put_byte(addr_b(pins, 1'b0), a);      check(a, "R2 address ack", int'(a), 1);
        put_byte(ins_b(3'b100, 2'd0), a);     check(!a, "R4 read opcode with write direction", int'(a), 0);
        bus_stop();
        bus_start();
        put_byte(addr_b(pins, 1'b1), a);      check(a, "R2 address ack", int'(a), 1);
        put_byte(ins_b(3'b110, 2'd0), a);     check(!a, "R4 write-data opcode with read direction", int'(a), 0);
        bus_stop();
        bus_start();
        put_byte(addr_b(pins, 1'b0), a);      check(a, "R2 address ack", int'(a), 1);
        put_byte(8'b101_1_00_00, a);          check(!a, "R4 reserved bit set", int'(a), 0);
        put_byte(8'h03, a);                   check(!a, "R4 following byte ignored", int'(a), 0);
        bus_stop();

        // R9: frames cut short
        bus_start();
        put_byte(addr_b(pins, 1'b0), a);
        put_byte(ins_b(3'b101, 2'd0), a);
        put_byte(8'h01, a);                   check(a, "R9 partial write high byte ack", int'(a), 1);
        bus_stop();
        bus_start();
        put_byte(addr_b(pins, 1'b0), a);
        put_byte(ins_b(3'b110, 2'd2), a);     check(a, "R9 instruction-only write ack", int'(a), 1);
        bus_stop();
        rd_cmd(3'b100, 2'd0, 10'h3FF, 1'b0, 1'b0, got);
        check(got == 10'h3FF, "R9 wiper unchanged after short frame", int'(got), 10'h3FF);
        rd_cmd(3'b101, 2'd2, 10'h0AB, 1'b0, 1'b0, got);

        // R12: repeated start in the middle of a write
        bus_start();
        put_byte(addr_b(pins, 1'b0), a);
        put_byte(ins_b(3'b101, 2'd0), a);
        put_byte(8'h00, a);
        rd_cmd(3'b100, 2'd0, 10'h3FF, 1'b0, 1'b0, got);
        check(got == 10'h3FF, "R12 repeated start restarts address", int'(got), 10'h3FF);

        // R11: master acknowledges last byte, slave still releases
        rd_cmd(3'b101, 2'd0, 10'h111, 1'b1, 1'b1, got);

        // R2: other strap value
        pins = 2'b10;
        wq();
        wr_cmd(3'b101, 2'd0, 10'h055, 0);
        rd_cmd(3'b100, 2'd0, 10'h055, 1'b0, 1'b0, got);

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R9 every expected request seen", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule